// File: doc/BRIEF.md
# Bus Transaction Timing Monitor

A passive checker for a parallel shared bus with active-low handshake lines: a cycle-framing strobe, an initiator-ready strobe, a target-claim strobe and a target-stop strobe. It never drives the bus. The only cycles it looks at are those with the sampling enable `smp_en` high. Between samples the pins may do anything and nothing is recorded. Inside the monitor every pin is inverted to active-high. An edge means a difference between the present sample and the copy held from the previous sample.

Every time the framing strobe asserts, a transaction check starts. The check makes sure three things happen in time: the initiator shows ready, the data phase completes (reported by `xfer_done`), and the cycle does not end in a master abort too early. A second, independent recogniser looks for the ordered pattern that marks a target abort. A violation raises a one-clock pulse on its own error bit, sets the matching sticky bit and places a code on `err_code`. A recognised target abort raises `tabort_pulse`. A debug counter tracks framing edges that arrive while a check is still open.

The transaction checker has three states. In `M_IDLE` nothing is open. `M_NODEV` means open with no claim seen yet. `M_CLAIMED` means open with the claim seen. Its transitions are: *start* (framing asserts, from any state, to `M_NODEV`), *claim* (`M_NODEV` to `M_CLAIMED`), *complete*, *abort-end* and *deadline*, each going back to `M_IDLE`. The recogniser also has three states. In `T_IDLE` nothing is being tracked. In `T_WAIT_DEV` it waits for the claim. In `T_WAIT_STOP` it waits for the claim to change together with the stop strobe. Its transitions are: *arm* (framing asserts, to `T_WAIT_DEV`), *cancel* (framing deasserts in `T_WAIT_DEV`), *claimed* (to `T_WAIT_STOP`), *hit* and *miss* (the claim changes, with or without the stop strobe asserting, both back to `T_IDLE`).

Top module: `pci_txn_monitor`

## Requirements
- R1: State, counters and outputs advance only on clocks where `smp_en` is 1. A clock with `smp_en` 0 produces no pulse and leaves `restart_cnt` unchanged, whatever the pins do.
- R2: Pins are active-low. An assertion edge of the framing strobe is a sample in which `frame_n` is 0 and the previous sample's `frame_n` was 1. Holding `frame_n` low starts no new check.
- R3: The sample where framing asserts is offset 0. If `irdy_n` is not 0 in any sample at offsets 1 through 8, `err_pulse[0]` fires for the offset-8 sample with `err_code` 1. Ready at offset 8 is legal.
- R4: `xfer_done` high at any offset from 1 to 16 ends the check normally. If the check is still open at offset 16, `err_pulse[2]` fires with `err_code` 3.
- R5: Suppose `devsel_n` stayed 1 at every offset up to and including k, and `frame_n` deasserts at offset k. This ends the check as a master abort. The abort is legal for k of 5 or more. For k of 4 or less, `err_pulse[1]` fires with `err_code` 2.
- R6: `tabort_pulse` fires when three things happen in order. First, framing asserts. Later, `devsel_n` asserts with no framing deassertion between. Finally, `devsel_n` changes in the same sample in which `stop_n` asserts.
- R7: Target-abort recognition is cancelled in two cases: `devsel_n` changes without `stop_n` asserting in that sample, or framing deasserts before the claim.
- R8: Each pulse output is high for exactly the one clock after the sampling edge that caused it. Each error pulse sets its sticky bit in `err_sticky` in that same clock. `err_code` is 0 whenever no error pulse is high.
- R9: `clr_sticky` high on a clock clears `err_sticky`. A pulse on that same clock still sets its bit.
- R10: Suppose framing asserts while either check is open. Both checks restart from offset 0 and `restart_cnt` increments, wrapping at its width.
- R11: A synchronous active-high `rst` clears all state, the stored samples, the pulses, `err_sticky` and `restart_cnt`.
- R12: Completion takes precedence. Once `xfer_done` ends a check, no ready, abort or deadline error is raised for that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Qualified sampling enable |
| frame_n | input | 1 | Cycle-framing strobe, active low |
| irdy_n | input | 1 | Initiator-ready strobe, active low |
| devsel_n | input | 1 | Target-claim strobe, active low |
| stop_n | input | 1 | Target-stop strobe, active low |
| xfer_done | input | 1 | Data-phase completion indication, active high |
| clr_sticky | input | 1 | Clears the sticky error bits |
| err_pulse | output | 3 | One-clock error pulses: [0] ready late, [1] early abort, [2] deadline missed |
| err_sticky | output | 3 | Sticky copies of the error pulses |
| err_code | output | 2 | Code of the pulsing error: 0 none, 1 ready, 2 abort, 3 deadline |
| tabort_pulse | output | 1 | One-clock target-abort event |
| restart_cnt | output | RCNT_W | Count of framing edges that arrived with a check open |

## Verification
The bench targets the boundaries of the three windows: ready at offsets 8 and 9, framing deassertion at offsets 4 and 5, and completion at offset 16 or missing. A window off by one fires on the legal case or stays silent on the late one. The target-abort pattern is run once clean and once with an early claim change. A recogniser that tolerates the early change reports an abort nobody performed. Sampling gaps in which the pins toggle and an early completion with ready never shown catch two faults. One is a design that reads pins on every clock. The other lets a finished transaction raise errors.

// File: rtl/pcimon_pkg.sv
package pcimon_pkg;
    // bit positions inside the sampled line vector
    localparam int LN_FRAME  = 0;
    localparam int LN_IRDY   = 1;
    localparam int LN_DEVSEL = 2;
    localparam int LN_STOP   = 3;
    localparam int NUM_LINES = 4;

    // error bit positions
    localparam int EB_IRDY   = 0;
    localparam int EB_MABORT = 1;
    localparam int EB_TERM   = 2;
    localparam int NUM_ERR   = 3;

    typedef enum logic [1:0] {
        M_IDLE    = 2'd0,
        M_NODEV   = 2'd1,
        M_CLAIMED = 2'd2
    } txn_st_e;

    typedef enum logic [1:0] {
        T_IDLE      = 2'd0,
        T_WAIT_DEV  = 2'd1,
        T_WAIT_STOP = 2'd2
    } ta_st_e;

    typedef enum logic [1:0] {
        VC_NONE   = 2'd0,
        VC_IRDY   = 2'd1,
        VC_MABORT = 2'd2,
        VC_TERM   = 2'd3
    } vcode_e;
endpackage

// File: rtl/pcimon_sampler.sv
module pcimon_sampler
    import pcimon_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_en,
    input  logic [NUM_LINES-1:0] pins_n,
    output logic [NUM_LINES-1:0] cur,
    output logic [NUM_LINES-1:0] asrt,
    output logic [NUM_LINES-1:0] deas
);
    logic [NUM_LINES-1:0] prev_q;

    assign cur = ~pins_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else if (smp_en) begin
            prev_q <= cur;
        end
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_edge
        assign asrt[g] = cur[g] & ~prev_q[g];
        assign deas[g] = ~cur[g] & prev_q[g];
    end
endmodule

// File: rtl/pcimon_txn_fsm.sv
module pcimon_txn_fsm
    import pcimon_pkg::*;
#(
    parameter int IRDY_LIMIT = 8,
    parameter int DONE_LIMIT = 16,
    parameter int MABORT_MIN = 5,
    parameter int RCNT_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_en,
    input  logic [NUM_LINES-1:0] cur,
    input  logic [NUM_LINES-1:0] asrt,
    input  logic [NUM_LINES-1:0] deas,
    input  logic                 xfer_done,
    input  logic                 ta_busy,
    output logic                 irdy_late,
    output logic                 mabort_early,
    output logic                 term_miss,
    output logic [RCNT_W-1:0]    restart_cnt
);
    localparam int OFF_W = $clog2(DONE_LIMIT + 1);
    localparam logic [OFF_W-1:0] OFF_IRDY = OFF_W'(IRDY_LIMIT);
    localparam logic [OFF_W-1:0] OFF_DONE = OFF_W'(DONE_LIMIT);
    localparam logic [OFF_W-1:0] OFF_MAB  = OFF_W'(MABORT_MIN);

    txn_st_e           st_q, st_d;
    logic [OFF_W-1:0]  off_q, off_d, off_inc;
    logic              ipend_q, ipend_d;
    logic              restart;

    assign off_inc = off_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= M_IDLE;
            off_q       <= '0;
            ipend_q     <= 1'b0;
            restart_cnt <= '0;
        end else begin
            st_q    <= st_d;
            off_q   <= off_d;
            ipend_q <= ipend_d;
            if (restart) begin
                restart_cnt <= restart_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        st_d         = st_q;
        off_d        = off_q;
        ipend_d      = ipend_q;
        irdy_late    = 1'b0;
        mabort_early = 1'b0;
        term_miss    = 1'b0;
        restart      = 1'b0;
        if (smp_en) begin
            if (asrt[LN_FRAME]) begin
                // start: a new framing edge always reopens the check
                restart = (st_q != M_IDLE) || ta_busy;
                st_d    = M_NODEV;
                off_d   = '0;
                ipend_d = 1'b1;
            end else begin
                unique case (st_q)
                    M_IDLE: begin
                        st_d = M_IDLE;
                    end
                    M_NODEV, M_CLAIMED: begin
                        off_d = off_inc;
                        if (xfer_done) begin
                            // complete
                            st_d    = M_IDLE;
                            ipend_d = 1'b0;
                        end else if (st_q == M_NODEV && !cur[LN_DEVSEL] && deas[LN_FRAME]) begin
                            // abort-end
                            mabort_early = (off_inc < OFF_MAB);
                            st_d         = M_IDLE;
                            ipend_d      = 1'b0;
                        end else if (off_inc == OFF_DONE) begin
                            // deadline
                            term_miss = 1'b1;
                            st_d      = M_IDLE;
                            ipend_d   = 1'b0;
                        end else begin
                            if (st_q == M_NODEV && cur[LN_DEVSEL]) begin
                                st_d = M_CLAIMED;   // claim
                            end
                            if (ipend_q) begin
                                if (cur[LN_IRDY]) begin
                                    ipend_d = 1'b0;
                                end else if (off_inc == OFF_IRDY) begin
                                    irdy_late = 1'b1;
                                    ipend_d   = 1'b0;
                                end
                            end
                        end
                    end
                    default: begin
                        st_d = M_IDLE;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/pcimon_tabort_fsm.sv
module pcimon_tabort_fsm
    import pcimon_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_en,
    input  logic [NUM_LINES-1:0] asrt,
    input  logic [NUM_LINES-1:0] deas,
    output logic                 ta_hit,
    output logic                 ta_busy
);
    ta_st_e st_q, st_d;
    logic   dev_chg;

    assign dev_chg = asrt[LN_DEVSEL] | deas[LN_DEVSEL];
    assign ta_busy = (st_q != T_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= T_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        ta_hit = 1'b0;
        if (smp_en) begin
            if (asrt[LN_FRAME]) begin
                st_d = T_WAIT_DEV;                  // arm
            end else begin
                unique case (st_q)
                    T_IDLE: begin
                        st_d = T_IDLE;
                    end
                    T_WAIT_DEV: begin
                        if (deas[LN_FRAME]) begin
                            st_d = T_IDLE;          // cancel
                        end else if (asrt[LN_DEVSEL]) begin
                            st_d = T_WAIT_STOP;     // claimed
                        end
                    end
                    T_WAIT_STOP: begin
                        if (dev_chg) begin
                            ta_hit = asrt[LN_STOP]; // hit or miss
                            st_d   = T_IDLE;
                        end
                    end
                    default: begin
                        st_d = T_IDLE;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/pcimon_flags.sv
module pcimon_flags
    import pcimon_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_sticky,
    input  logic [NUM_ERR-1:0] viol,
    input  logic               ta_hit,
    output logic [NUM_ERR-1:0] err_pulse,
    output logic [NUM_ERR-1:0] err_sticky,
    output logic [1:0]         err_code,
    output logic               tabort_pulse
);
    vcode_e code_d;

    always_comb begin
        if (viol[EB_TERM])        code_d = VC_TERM;
        else if (viol[EB_MABORT]) code_d = VC_MABORT;
        else if (viol[EB_IRDY])   code_d = VC_IRDY;
        else                      code_d = VC_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_pulse    <= '0;
            err_code     <= VC_NONE;
            tabort_pulse <= 1'b0;
        end else begin
            err_pulse    <= viol;
            err_code     <= code_d;
            tabort_pulse <= ta_hit;
        end
    end

    for (genvar g = 0; g < NUM_ERR; g++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (rst) begin
                err_sticky[g] <= 1'b0;
            end else if (viol[g]) begin
                err_sticky[g] <= 1'b1;
            end else if (clr_sticky) begin
                err_sticky[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pci_txn_monitor.sv
module pci_txn_monitor
    import pcimon_pkg::*;
#(
    parameter int IRDY_LIMIT = 8,
    parameter int DONE_LIMIT = 16,
    parameter int MABORT_MIN = 5,
    parameter int RCNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_en,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              devsel_n,
    input  logic              stop_n,
    input  logic              xfer_done,
    input  logic              clr_sticky,
    output logic [2:0]        err_pulse,
    output logic [2:0]        err_sticky,
    output logic [1:0]        err_code,
    output logic              tabort_pulse,
    output logic [RCNT_W-1:0] restart_cnt
);
    logic [NUM_LINES-1:0] pins_n, cur, asrt, deas;
    logic [NUM_ERR-1:0]   viol;
    logic                 ta_hit, ta_busy;

    always_comb begin
        pins_n            = '1;
        pins_n[LN_FRAME]  = frame_n;
        pins_n[LN_IRDY]   = irdy_n;
        pins_n[LN_DEVSEL] = devsel_n;
        pins_n[LN_STOP]   = stop_n;
    end

    pcimon_sampler u_smp (
        .clk    (clk),
        .rst    (rst),
        .smp_en (smp_en),
        .pins_n (pins_n),
        .cur    (cur),
        .asrt   (asrt),
        .deas   (deas)
    );

    pcimon_txn_fsm #(
        .IRDY_LIMIT (IRDY_LIMIT),
        .DONE_LIMIT (DONE_LIMIT),
        .MABORT_MIN (MABORT_MIN),
        .RCNT_W     (RCNT_W)
    ) u_txn (
        .clk          (clk),
        .rst          (rst),
        .smp_en       (smp_en),
        .cur          (cur),
        .asrt         (asrt),
        .deas         (deas),
        .xfer_done    (xfer_done),
        .ta_busy      (ta_busy),
        .irdy_late    (viol[EB_IRDY]),
        .mabort_early (viol[EB_MABORT]),
        .term_miss    (viol[EB_TERM]),
        .restart_cnt  (restart_cnt)
    );

    pcimon_tabort_fsm u_ta (
        .clk     (clk),
        .rst     (rst),
        .smp_en  (smp_en),
        .asrt    (asrt),
        .deas    (deas),
        .ta_hit  (ta_hit),
        .ta_busy (ta_busy)
    );

    pcimon_flags u_flg (
        .clk          (clk),
        .rst          (rst),
        .clr_sticky   (clr_sticky),
        .viol         (viol),
        .ta_hit       (ta_hit),
        .err_pulse    (err_pulse),
        .err_sticky   (err_sticky),
        .err_code     (err_code),
        .tabort_pulse (tabort_pulse)
    );
endmodule

// File: rtl/pci_txn_monitor_chk.sv
module pci_txn_monitor_chk #(
    parameter int RCNT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_en,
    input logic              clr_sticky,
    input logic [2:0]        err_pulse,
    input logic [2:0]        err_sticky,
    input logic [1:0]        err_code,
    input logic              tabort_pulse,
    input logic [RCNT_W-1:0] restart_cnt
);
    AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> (err_pulse == 3'b000 && !tabort_pulse)); // R1
    AST_RCNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> $stable(restart_cnt)); // R1
    AST_IRDY_CODE: assert property (@(posedge clk) disable iff (rst)
        err_pulse[0] |-> err_code == 2'd1); // R3
    AST_TERM_CODE: assert property (@(posedge clk) disable iff (rst)
        err_pulse[2] |-> err_code == 2'd3); // R4
    AST_MABORT_CODE: assert property (@(posedge clk) disable iff (rst)
        err_pulse[1] |-> err_code == 2'd2); // R5
    AST_TA_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tabort_pulse |=> !tabort_pulse); // R6
    AST_ONE_ERROR: assert property (@(posedge clk) disable iff (rst)
        $onehot0(err_pulse)); // R8
    AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
        (err_pulse != 3'b000) |-> ((err_sticky & err_pulse) == err_pulse)); // R8
    AST_CODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (err_pulse == 3'b000) |-> err_code == 2'd0); // R8
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
        !clr_sticky |=> ((err_sticky & $past(err_sticky)) == $past(err_sticky))); // R9
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        clr_sticky |=> ((err_sticky & ~err_pulse) == 3'b000)); // R9
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (err_sticky == 3'b000 && err_pulse == 3'b000 && !tabort_pulse
                 && restart_cnt == '0)); // R11
endmodule

bind pci_txn_monitor pci_txn_monitor_chk #(.RCNT_W(RCNT_W)) u_chk (.*);

// File: tb/pci_txn_monitor_tb.sv
module pci_txn_monitor_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_en = 1'b0;
    logic frame_n = 1'b1, irdy_n = 1'b1, devsel_n = 1'b1, stop_n = 1'b1;
    logic xfer_done = 1'b0, clr_sticky = 1'b0;
    logic [2:0] err_pulse, err_sticky;
    logic [1:0] err_code;
    logic       tabort_pulse;
    logic [7:0] restart_cnt;

    always #4 clk = ~clk;   // 125 MHz

    pci_txn_monitor u_dut (
        .clk(clk), .rst(rst), .smp_en(smp_en),
        .frame_n(frame_n), .irdy_n(irdy_n), .devsel_n(devsel_n), .stop_n(stop_n),
        .xfer_done(xfer_done), .clr_sticky(clr_sticky),
        .err_pulse(err_pulse), .err_sticky(err_sticky), .err_code(err_code),
        .tabort_pulse(tabort_pulse), .restart_cnt(restart_cnt)
    );

    int    checks = 0;
    int    errors = 0;
    int    ta_seen = 0;
    int    cyc = 0;
    bit    started = 0;
    bit    finished = 0;
    string cur_req = "R11";

    // behavioural reference state
    bit m_busy, m_claim, m_ip;
    int m_off, m_ta;
    bit p_fr, p_ir, p_dv, p_st;
    int e_pulse, e_sticky, e_code, e_rc;
    bit e_ta;

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit fr, ir, dv, st;
        started = 1;
        if (rst) begin
            m_busy = 0; m_claim = 0; m_ip = 0; m_off = 0; m_ta = 0;
            p_fr = 0; p_ir = 0; p_dv = 0; p_st = 0;
            e_pulse = 0; e_sticky = 0; e_code = 0; e_rc = 0; e_ta = 0;
        end else begin
            e_pulse = 0; e_code = 0; e_ta = 0;
            if (smp_en) begin
                fr = !frame_n; ir = !irdy_n; dv = !devsel_n; st = !stop_n;
                if (fr && !p_fr) begin
                    if (m_busy || m_ta != 0) e_rc = (e_rc + 1) % 256;
                    m_busy = 1; m_claim = 0; m_off = 0; m_ip = 1; m_ta = 1;
                end else begin
                    if (m_busy) begin
                        m_off++;
                        if (xfer_done) begin
                            m_busy = 0; m_ip = 0;
                        end else if (!m_claim && !dv && !fr && p_fr) begin
                            if (m_off < 5) begin e_pulse = 2; e_code = 2; end
                            m_busy = 0; m_ip = 0;
                        end else if (m_off == 16) begin
                            e_pulse = 4; e_code = 3; m_busy = 0; m_ip = 0;
                        end else begin
                            if (!m_claim && dv) m_claim = 1;
                            if (m_ip) begin
                                if (ir) m_ip = 0;
                                else if (m_off == 8) begin e_pulse = 1; e_code = 1; m_ip = 0; end
                            end
                        end
                    end
                    if (m_ta == 1) begin
                        if (!fr && p_fr) m_ta = 0;
                        else if (dv && !p_dv) m_ta = 2;
                    end else if (m_ta == 2) begin
                        if (dv != p_dv) begin
                            if (st && !p_st) e_ta = 1;
                            m_ta = 0;
                        end
                    end
                end
                p_fr = fr; p_ir = ir; p_dv = dv; p_st = st;
            end
            if (clr_sticky) e_sticky = 0;
            e_sticky = e_sticky | e_pulse;
        end
    end

    // cycle-by-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started && !finished) begin
            check(cur_req, err_pulse, e_pulse, "err_pulse");
            check(cur_req, err_sticky, e_sticky, "err_sticky");
            check(cur_req, err_code, e_code, "err_code");
            check(cur_req, tabort_pulse, e_ta, "tabort_pulse");
            check(cur_req, restart_cnt, e_rc, "restart_cnt");
            if (tabort_pulse === 1'b1) ta_seen++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // one sampled cycle; arguments are active-high
    task automatic smp(input bit fr, input bit ir, input bit dv, input bit st, input bit dn);
        @(negedge clk);
        frame_n = !fr; irdy_n = !ir; devsel_n = !dv; stop_n = !st;
        xfer_done = dn; smp_en = 1'b1; clr_sticky = 1'b0;
        @(posedge clk);
    endtask

    // one unsampled cycle with the pins toggled
    task automatic gap();
        @(negedge clk);
        smp_en = 1'b0; clr_sticky = 1'b0;
        frame_n = $urandom_range(0, 1); irdy_n = 1'b0;
        devsel_n = $urandom_range(0, 1); stop_n = $urandom_range(0, 1);
        xfer_done = $urandom_range(0, 1);
        @(posedge clk);
    endtask

    task automatic clear();
        @(negedge clk);
        smp_en = 1'b0; xfer_done = 1'b0; clr_sticky = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr_sticky = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) smp(0, 0, 0, 0, 0);
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    initial begin
        int ta_base;
        repeat (3) @(posedge clk);
        settle();
        check("R11", err_sticky, 0, "sticky at reset");
        check("R11", restart_cnt, 0, "restart at reset");
        rst = 1'b0;
        idle(2);

        // R3: ready exactly at offset 8 is legal
        cur_req = "R3";
        smp(1, 0, 0, 0, 0);
        for (int i = 1; i < 8; i++) smp(1, 0, 1, 0, 0);
        smp(1, 1, 1, 0, 0);
        smp(0, 1, 1, 0, 1);
        idle(2);
        settle();
        check("R3", err_sticky, 0, "ready at 8");
        check("R2", restart_cnt, 0, "held frame starts nothing new");

        // R3: ready at offset 9 is late
        smp(1, 0, 0, 0, 0);
        for (int i = 1; i <= 8; i++) smp(1, 0, 1, 0, 0);
        smp(1, 1, 1, 0, 0);
        smp(0, 1, 1, 0, 1);
        idle(2);
        settle();
        check("R3", err_sticky, 1, "ready at 9");

        cur_req = "R9";
        clear();
        settle();
        check("R9", err_sticky, 0, "after clear");

        // R5: framing deasserts at offset 4 with no claim
        cur_req = "R5";
        smp(1, 0, 0, 0, 0);
        for (int i = 1; i < 4; i++) smp(1, 1, 0, 0, 0);
        smp(0, 1, 0, 0, 0);
        idle(2);
        settle();
        check("R5", err_sticky, 2, "abort at 4");
        clear();

        // R5: offset 5 is legal
        smp(1, 0, 0, 0, 0);
        for (int i = 1; i < 5; i++) smp(1, 1, 0, 0, 0);
        smp(0, 1, 0, 0, 0);
        idle(20);
        settle();
        check("R5", err_sticky, 0, "abort at 5");

        // R4: deadline missed
        cur_req = "R4";
        smp(1, 0, 0, 0, 0);
        for (int i = 1; i <= 16; i++) smp(1, 1, 1, 0, 0);
        idle(2);
        settle();
        check("R4", err_sticky, 4, "no completion");
        clear();

        // R4: completion at offset 16 is in time
        smp(1, 0, 0, 0, 0);
        for (int i = 1; i < 16; i++) smp(1, 1, 1, 0, 0);
        smp(0, 1, 1, 0, 1);
        idle(2);
        settle();
        check("R4", err_sticky, 0, "completion at 16");

        // R6: clean target abort
        cur_req = "R6";
        ta_base = ta_seen;
        smp(1, 0, 0, 0, 0);
        smp(1, 1, 0, 0, 0);
        smp(1, 1, 1, 0, 0);
        smp(1, 1, 1, 0, 0);
        smp(1, 1, 0, 1, 0);
        smp(0, 0, 0, 1, 1);
        idle(2);
        settle();
        check("R6", ta_seen - ta_base, 1, "target abort seen");

        // R7: early claim change cancels recognition
        cur_req = "R7";
        ta_base = ta_seen;
        smp(1, 0, 0, 0, 0);
        smp(1, 1, 0, 0, 0);
        smp(1, 1, 1, 0, 0);
        smp(1, 1, 0, 0, 0);
        smp(1, 1, 1, 1, 0);
        smp(0, 0, 0, 1, 1);
        idle(2);
        settle();
        check("R7", ta_seen - ta_base, 0, "early claim change");

        // R7: framing deasserts before any claim
        ta_base = ta_seen;
        smp(1, 1, 0, 0, 0);
        smp(0, 1, 0, 0, 0);
        smp(0, 0, 1, 0, 0);
        smp(0, 0, 0, 1, 0);
        idle(2);
        settle();
        check("R7", ta_seen - ta_base, 0, "frame gone before claim");
        clear();

        // R10: framing edge with a check open
        cur_req = "R10";
        smp(1, 0, 0, 0, 0);
        smp(1, 1, 1, 0, 0);
        smp(1, 1, 1, 0, 0);
        smp(0, 1, 1, 0, 0);
        smp(1, 0, 1, 0, 0);
        smp(1, 1, 1, 0, 0);
        smp(0, 1, 1, 0, 1);
        idle(2);
        settle();
        check("R10", restart_cnt, 1, "restart counted");

        // R12: early completion with ready never shown
        cur_req = "R12";
        smp(1, 0, 0, 0, 0);
        smp(1, 0, 1, 0, 0);
        smp(1, 0, 1, 0, 0);
        smp(1, 0, 1, 0, 1);
        for (int i = 0; i < 20; i++) smp(1, 0, 1, 0, 0);
        idle(2);
        settle();
        check("R12", err_sticky, 0, "no error after completion");

        // R1: ready shown only in unsampled cycles still counts as late
        cur_req = "R1";
        smp(1, 0, 0, 0, 0);
        for (int i = 1; i <= 8; i++) begin
            gap();
            smp(1, 0, 1, 0, 0);
        end
        gap();
        smp(0, 1, 1, 0, 1);
        idle(2);
        settle();
        check("R1", err_sticky, 1, "gaps ignored");
        check("R1", restart_cnt, 1, "gaps leave counter");

        // R11: reset mid-transaction
        cur_req = "R11";
        smp(1, 0, 0, 0, 0);
        smp(1, 1, 1, 0, 0);
        @(negedge clk);
        rst = 1'b1; smp_en = 1'b0;
        repeat (2) @(posedge clk);
        settle();
        check("R11", err_sticky, 0, "sticky after reset");
        check("R11", restart_cnt, 0, "restart after reset");
        rst = 1'b0;
        idle(3);
        settle();

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule